// File: doc/BRIEF.md
# Dual Data Pointer Register Bank

This block keeps two 16-bit data pointers and a small control register behind a special-function-register (SFR) bus. The bus has an 8-bit address, a write enable, 8-bit write data and combinational 8-bit read data. Two byte addresses reach the low and high halves of whichever pointer is selected. A select bit in the control register decides which of the two pointers those byte addresses and the other pointer functions act on.

An increment strobe adds one to the selected pointer. A 16-bit external data address output always shows the selected pointer. Bit 2 of the control register is fixed at zero. Because of this, software that reads the control register, adds one and writes the result back flips the select bit and leaves the general-purpose flag unchanged. Writes take effect on the rising clock edge. Read data and the external address follow the stored state with no added cycle.

Top module: `dual_dptr_bank`

## Requirements
- R1: After reset the control register reads 00H, both pointers hold 0000H and `ext_addr` is 0000H.
- R2: The control register sits at address A2H. Bit 0 is the pointer select (0 picks pointer 0, 1 picks pointer 1) and is written and read back at bit 0.
- R3: Control bit 3 is a read/write flag. Writing it changes no pointer and does not change `ext_addr`.
- R4: Control bits 7..4, 2 and 1 always read 0 and ignore writes. Writing back the value read plus one toggles only bit 0 (for example 09H written as 0AH reads back as 08H).
- R5: Address 82H reads and writes the low byte of the selected pointer. Address 83H reads and writes its high byte.
- R6: `ext_addr` equals the selected pointer. It switches to the other pointer's value in the cycle after the select bit is written.
- R7: A cycle with `ptr_inc` high adds one to the selected pointer, with carry from the low byte into the high byte. FFFFH wraps to 0000H.
- R8: The pointer that is not selected keeps its value through writes and increments aimed at the selected one.
- R9: If a write to 82H or 83H falls in the same cycle as `ptr_inc`, the written byte is stored, the other byte is unchanged and the increment is dropped.
- R10: If a write to A2H falls in the same cycle as `ptr_inc`, the increment goes to the pointer that was selected before that write.
- R11: Any address other than 82H, 83H and A2H reads 00H, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_addr | input | 8 | SFR bus address |
| sfr_we | input | 1 | SFR write enable |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, combinational from `sfr_addr` |
| ptr_inc | input | 1 | Increment strobe for the selected pointer |
| ext_addr | output | 16 | External data address, the selected pointer |

## Verification
The increment strobe can arrive in the same cycle as an SFR write. The write may target a pointer byte or the control register. The bench drives `ptr_inc` together with writes to 82H, to 83H and to A2H. One clock later it reads `ext_addr` and the pointer bytes. It judges each result against one rule: a byte write wins over the increment, and a select change lets the increment land on the pointer that was selected before the change. It also confirms that the pointer that was not touched still holds its earlier value.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

   // Position of the fields inside the control register.
   localparam int CTL_SEL_BIT  = 0;
   localparam int CTL_ZERO_BIT = 2;
   localparam int CTL_FLAG_BIT = 3;

   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_LO   = 2'd1,
      HIT_HI   = 2'd2,
      HIT_CTL  = 2'd3
   } sfr_hit_e;

endpackage

// File: rtl/dptr_decode.sv
module dptr_decode
   import dptr_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter logic [7:0]  LO_ADDR  = 8'h82,
   parameter logic [7:0]  HI_ADDR  = 8'h83,
   parameter logic [7:0]  CTL_ADDR = 8'hA2
) (
   input  logic [ADDR_W-1:0] addr_i,
   output sfr_hit_e          hit_o
);

   if (ADDR_W < 8) begin : g_width_chk
      initial $fatal(1, "dptr_decode: ADDR_W must be at least 8");
   end
   if (LO_ADDR == HI_ADDR || LO_ADDR == CTL_ADDR || HI_ADDR == CTL_ADDR) begin : g_addr_chk
      initial $fatal(1, "dptr_decode: register addresses must differ");
   end

   localparam logic [ADDR_W-1:0] LO_A  = ADDR_W'(LO_ADDR);
   localparam logic [ADDR_W-1:0] HI_A  = ADDR_W'(HI_ADDR);
   localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);

   always_comb begin
      if (addr_i == LO_A)       hit_o = HIT_LO;
      else if (addr_i == HI_A)  hit_o = HIT_HI;
      else if (addr_i == CTL_A) hit_o = HIT_CTL;
      else                      hit_o = HIT_NONE;
   end

endmodule

// File: rtl/dptr_ctrl.sv
module dptr_ctrl
   import dptr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              sel_o,
   output logic [DATA_W-1:0] rd_o
);

   if (DATA_W <= CTL_FLAG_BIT) begin : g_width_chk
      initial $fatal(1, "dptr_ctrl: DATA_W too narrow for control fields");
   end

   logic sel_q;
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         flag_q <= 1'b0;
      end else if (wr_i) begin
         sel_q  <= wdata_i[CTL_SEL_BIT];
         flag_q <= wdata_i[CTL_FLAG_BIT];
      end
   end

   always_comb begin
      rd_o               = '0;
      rd_o[CTL_SEL_BIT]  = sel_q;
      rd_o[CTL_FLAG_BIT] = flag_q;
   end

   assign sel_o = sel_q;

   // R2
   sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> sel_q == $past(wdata_i[CTL_SEL_BIT]));

   // R3
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(flag_q) && $stable(sel_q));

endmodule

// File: rtl/dptr_ptr.sv
module dptr_ptr #(
   parameter int DATA_W = 8,
   parameter int PTR_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_me_i,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic              inc_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [PTR_W-1:0]  val_o
);

   if (PTR_W != 2 * DATA_W) begin : g_width_chk
      initial $fatal(1, "dptr_ptr: PTR_W must be twice DATA_W");
   end

   logic [PTR_W-1:0] val_q;
   logic             do_lo, do_hi, do_inc;

   assign do_lo  = sel_me_i && wr_lo_i;
   assign do_hi  = sel_me_i && wr_hi_i;
   assign do_inc = sel_me_i && inc_i && !wr_lo_i && !wr_hi_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q <= '0;
      else if (do_lo)  val_q <= {val_q[PTR_W-1:DATA_W], wdata_i};
      else if (do_hi)  val_q <= {wdata_i, val_q[DATA_W-1:0]};
      else if (do_inc) val_q <= val_q + 1'b1;
   end

   assign val_o = val_q;

   // R7
   inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_me_i && inc_i && !wr_lo_i && !wr_hi_i) |=> val_q == $past(val_q) + 1'b1);

   // R8
   unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_me_i |=> $stable(val_q));

   // R9
   lo_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_me_i && wr_lo_i) |=> val_q == {$past(val_q[PTR_W-1:DATA_W]), $past(wdata_i)});

endmodule

// File: rtl/dual_dptr_bank.sv
module dual_dptr_bank
   import dptr_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          DATA_W   = 8,
   parameter logic [7:0]  LO_ADDR  = 8'h82,
   parameter logic [7:0]  HI_ADDR  = 8'h83,
   parameter logic [7:0]  CTL_ADDR = 8'hA2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   sfr_addr,
   input  logic                sfr_we,
   input  logic [DATA_W-1:0]   sfr_wdata,
   output logic [DATA_W-1:0]   sfr_rdata,
   input  logic                ptr_inc,
   output logic [2*DATA_W-1:0] ext_addr
);

   localparam int PTR_W   = 2 * DATA_W;
   localparam int NUM_PTR = 2;

   sfr_hit_e          hit;
   logic              sel;
   logic [DATA_W-1:0] ctl_rd;
   logic [PTR_W-1:0]  ptr_val [NUM_PTR];
   logic [PTR_W-1:0]  cur_ptr;
   logic              wr_lo, wr_hi, wr_ctl;

   dptr_decode #(
      .ADDR_W   (ADDR_W),
      .LO_ADDR  (LO_ADDR),
      .HI_ADDR  (HI_ADDR),
      .CTL_ADDR (CTL_ADDR)
   ) u_decode (
      .addr_i (sfr_addr),
      .hit_o  (hit)
   );

   assign wr_lo  = sfr_we && (hit == HIT_LO);
   assign wr_hi  = sfr_we && (hit == HIT_HI);
   assign wr_ctl = sfr_we && (hit == HIT_CTL);

   dptr_ctrl #(
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_ctl),
      .wdata_i (sfr_wdata),
      .sel_o   (sel),
      .rd_o    (ctl_rd)
   );

   for (genvar gi = 0; gi < NUM_PTR; gi++) begin : g_ptr
      dptr_ptr #(
         .DATA_W (DATA_W),
         .PTR_W  (PTR_W)
      ) u_ptr (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel_me_i (sel == gi[0]),
         .wr_lo_i  (wr_lo),
         .wr_hi_i  (wr_hi),
         .inc_i    (ptr_inc),
         .wdata_i  (sfr_wdata),
         .val_o    (ptr_val[gi])
      );
   end

   assign cur_ptr  = sel ? ptr_val[1] : ptr_val[0];
   assign ext_addr = cur_ptr;

   always_comb begin
      unique case (hit)
         HIT_LO:  sfr_rdata = cur_ptr[DATA_W-1:0];
         HIT_HI:  sfr_rdata = cur_ptr[PTR_W-1:DATA_W];
         HIT_CTL: sfr_rdata = ctl_rd;
         default: sfr_rdata = '0;
      endcase
   end

   // R4
   ctl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == HIT_CTL) |-> (sfr_rdata[CTL_ZERO_BIT] == 1'b0 && sfr_rdata[DATA_W-1:CTL_FLAG_BIT+1] == '0
                            && sfr_rdata[1] == 1'b0));

   // R11
   other_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == HIT_NONE) |-> sfr_rdata == '0);

   // R10
   ctl_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && ptr_inc && !sel) |=> ptr_val[0] == $past(ptr_val[0]) + 1'b1);

   // R5
   hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> ext_addr[PTR_W-1:DATA_W] == $past(sfr_wdata));

endmodule

// File: tb/dual_dptr_bank_bench.sv
module dual_dptr_bank_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  sfr_addr = 8'h00;
   logic        sfr_we = 1'b0;
   logic [7:0]  sfr_wdata = 8'h00;
   logic [7:0]  sfr_rdata;
   logic        ptr_inc = 1'b0;
   logic [15:0] ext_addr;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   dual_dptr_bank u_dual_dptr_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .sfr_addr  (sfr_addr),
      .sfr_we    (sfr_we),
      .sfr_wdata (sfr_wdata),
      .sfr_rdata (sfr_rdata),
      .ptr_inc   (ptr_inc),
      .ext_addr  (ext_addr)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // One clock with the given bus activity; ends 1 ns after the edge.
   task automatic cycle(input logic [7:0] a, input logic we, input logic [7:0] d, input logic inc);
      @(negedge clk);
      sfr_addr  = a;
      sfr_we    = we;
      sfr_wdata = d;
      ptr_inc   = inc;
      @(posedge clk);
      #1;
      sfr_we  = 1'b0;
      ptr_inc = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      cycle(a, 1'b1, d, 1'b0);
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      sfr_we   = 1'b0;
      sfr_addr = a;
      #1;
      d = sfr_rdata;
   endtask

   task automatic set_ptr(input logic [15:0] v);
      wr(8'h82, v[7:0]);
      wr(8'h83, v[15:8]);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(8'hA2, d); check("R1 ctl", {8'h0, d}, 16'h0000);
      rd(8'h82, d); check("R1 lo", {8'h0, d}, 16'h0000);
      rd(8'h83, d); check("R1 hi", {8'h0, d}, 16'h0000);
      check("R1 ext_addr", ext_addr, 16'h0000);
   endtask

   task automatic t_ctrl();
      logic [7:0] d;
      wr(8'hA2, 8'h01);
      rd(8'hA2, d); check("R2 select set", {8'h0, d}, 16'h0001);
      wr(8'hA2, 8'hFF);
      rd(8'hA2, d); check("R4 reserved ignored", {8'h0, d}, 16'h0009);
      wr(8'hA2, 8'h08);
      rd(8'hA2, d); check("R3 flag only", {8'h0, d}, 16'h0008);
      check("R3 ext unchanged", ext_addr, 16'h0000);
   endtask

   task automatic t_bytes();
      logic [7:0] d;
      wr(8'hA2, 8'h00);
      set_ptr(16'h1234);
      check("R5 ptr0 write", ext_addr, 16'h1234);
      rd(8'h82, d); check("R5 lo read", {8'h0, d}, 16'h0034);
      rd(8'h83, d); check("R5 hi read", {8'h0, d}, 16'h0012);
      wr(8'hA2, 8'h01);
      check("R6 switch to ptr1", ext_addr, 16'h0000);
      set_ptr(16'hABCD);
      rd(8'h82, d); check("R5 ptr1 lo", {8'h0, d}, 16'h00CD);
      wr(8'hA2, 8'h00);
      check("R8 ptr0 kept", ext_addr, 16'h1234);
      rd(8'h83, d); check("R6 hi follows select", {8'h0, d}, 16'h0012);
   endtask

   task automatic t_toggle();
      logic [7:0] d;
      wr(8'hA2, 8'h08);
      rd(8'hA2, d);
      wr(8'hA2, d + 8'h01);
      rd(8'hA2, d); check("R4 toggle up", {8'h0, d}, 16'h0009);
      check("R4 toggle ext", ext_addr, 16'hABCD);
      wr(8'hA2, d + 8'h01);
      rd(8'hA2, d); check("R4 toggle down", {8'h0, d}, 16'h0008);
      check("R4 toggle ext back", ext_addr, 16'h1234);
   endtask

   task automatic t_inc();
      set_ptr(16'h00FF);
      cycle(8'h00, 1'b0, 8'h00, 1'b1);
      check("R7 carry", ext_addr, 16'h0100);
      set_ptr(16'hFFFF);
      cycle(8'h00, 1'b0, 8'h00, 1'b1);
      check("R7 wrap", ext_addr, 16'h0000);
      for (int i = 0; i < 3; i++) cycle(8'h00, 1'b0, 8'h00, 1'b1);
      check("R7 repeated", ext_addr, 16'h0003);
      wr(8'hA2, 8'h01);
      check("R8 ptr1 kept", ext_addr, 16'hABCD);
      wr(8'hA2, 8'h00);
   endtask

   task automatic t_collide();
      set_ptr(16'h10FF);
      cycle(8'h82, 1'b1, 8'h55, 1'b1);
      check("R9 lo write wins", ext_addr, 16'h1055);
      cycle(8'h83, 1'b1, 8'h77, 1'b1);
      check("R9 hi write wins", ext_addr, 16'h7755);
      cycle(8'hA2, 1'b1, 8'h01, 1'b1);
      check("R10 ptr1 untouched", ext_addr, 16'hABCD);
      wr(8'hA2, 8'h00);
      check("R10 old pointer incremented", ext_addr, 16'h7756);
   endtask

   task automatic t_other();
      logic [7:0] d;
      wr(8'h81, 8'hFF);
      rd(8'h81, d); check("R11 other reads zero", {8'h0, d}, 16'h0000);
      rd(8'hA2, d); check("R11 ctl unchanged", {8'h0, d}, 16'h0000);
      check("R11 ext unchanged", ext_addr, 16'h7756);
   endtask

   initial begin
      fork
         begin
            #10;
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_ctrl();
            t_bytes();
            t_toggle();
            t_inc();
            t_collide();
            t_other();
         end
         begin
            repeat (20000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule